// File: doc/BRIEF.md
# Four-Read-Port Mirrored Memory

This block is a word-addressed memory that serves up to four reads in one clock cycle. It is built only from single-port synchronous SRAM banks. There are four identical banks and each one holds a full copy of the contents. Each read port owns one bank, so the four ports can read four unrelated addresses at the same time.

A write goes to all four banks in the same cycle, which keeps the copies equal. Each bank can do only one operation per clock, so a write takes every bank for that cycle. Any read requested in that cycle is refused and must be requested again.

Each read port has a request, an address, a ready flag, a valid flag and a data bus. Ready tells the requester in the same cycle whether its request was taken. Valid marks the cycle in which the data for a taken request is on the data bus. A single stall flag reports that at least one read lost to a write. The depth and the word width are parameters, with defaults of 64 words by 32 bits.

Top module: `mirror_rd4_mem`

## Requirements
- R1: While rst_n is low at a clock edge, every bit of rd_valid is 0 after that edge.
- R2: In any cycle where wr_req is 0, rd_ready[i] equals rd_req[i] for every port, and rd_stall is 0.
- R3: A read accepted in cycle t (rd_req[i]=1, wr_req=0) gives rd_valid[i]=1 in cycle t+1. In that cycle rd_data for that port holds the word stored at the requested address at the end of cycle t.
- R4: The four ports read independently. Different addresses presented on all four ports in one cycle each return their own word in the next cycle.
- R5: A write (wr_req=1) stores wr_data at wr_addr in every bank in that cycle. A later read of that address on any port returns that value.
- R6: A write has priority. When wr_req=1, every rd_ready bit is 0, and rd_stall is 1 exactly when some rd_req bit is 1. No port shows rd_valid=1 in the next cycle.
- R7: A read refused under R6 and requested again in a later cycle without a write is accepted and returns the current contents.
- R8: A read accepted in the cycle right after a write to the same address returns the newly written word.
- R9: A port that makes no accepted read in cycle t shows rd_valid[i]=0 in cycle t+1.
- R10: Port i takes its address from rd_addr[i*AW +: AW] and puts its word on rd_data[i*WIDTH +: WIDTH], where AW = clog2(DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | NPORTS | Per-port read request |
| rd_addr | input | NPORTS*AW | Packed read addresses, port i at bits i*AW +: AW |
| rd_ready | output | NPORTS | Per-port request accepted this cycle |
| rd_stall | output | 1 | Some read was refused because of a write |
| rd_valid | output | NPORTS | Per-port read data valid |
| rd_data | output | NPORTS*WIDTH | Packed read data, port i at bits i*WIDTH +: WIDTH |
| wr_req | input | 1 | Write request, sent to all banks |
| wr_addr | input | AW | Write address |
| wr_data | input | WIDTH | Write data |

## Verification
Suppose one bank misses a write, or decodes an address the wrong way. Its copy then differs from the reference. The bench will see this on the next read of that word through that one port, one cycle after the read is accepted, even though the other ports still agree. An error in the grant or valid logic shows in the same cycle on rd_ready and rd_stall, or one cycle later as a valid flag that is missing or should not be there. Every port is compared on every clock against one behavioural array, so a divergence is reported at its first observable read.

// File: rtl/mrm_pkg.sv
// Package: shared types for the mirrored multi-read memory.
// Assumes: one operation per bank per clock.
package mrm_pkg;

    typedef enum logic [1:0] {
        BANK_IDLE  = 2'd0,
        BANK_READ  = 2'd1,
        BANK_WRITE = 2'd2
    } bank_op_e;

endpackage

// File: rtl/mrm_bank.sv
// Module: behavioural single-port synchronous SRAM bank.
// Performs exactly one operation per clock (idle, read or write). Address,
// data and operation are captured on the rising edge; read data appears
// after that edge and holds until the next read.
// Assumes: contents are not reset; only the output register is.
module mrm_bank
    import mrm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Storage array: commit a write on the edge.
    always_ff @(posedge clk) begin
        if (op == BANK_WRITE) begin
            mem[addr] <= wdata;
        end
    end

    // Output register: capture the addressed word on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (op == BANK_READ) begin
            rdata <= mem[addr];
        end
    end

    // R3: output changes only after a read operation
    p_hold_without_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op != BANK_READ) |=> $stable(rdata));

endmodule

// File: rtl/mrm_arbiter.sv
// Module: read/write arbiter for the mirrored banks.
// A write takes every bank, so it wins over all reads in that cycle.
// Otherwise each port's request becomes a read on its own bank.
// Assumes: one write channel, NPORTS read ports, one bank per port.
module mrm_arbiter
    import mrm_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] rd_req,
    input  logic              wr_req,
    output logic [NPORTS-1:0] rd_grant,
    output logic              rd_stall,
    output bank_op_e          bank_op [NPORTS]
);

    // Grant reads only when no write claims the banks.
    always_comb begin
        rd_grant = wr_req ? '0 : rd_req;
        rd_stall = wr_req && (|rd_req);
    end

    genvar g;
    generate
        for (g = 0; g < NPORTS; g++) begin : g_op
            // Per-bank operation select.
            always_comb begin
                if (wr_req) begin
                    bank_op[g] = BANK_WRITE;
                end else if (rd_req[g]) begin
                    bank_op[g] = BANK_READ;
                end else begin
                    bank_op[g] = BANK_IDLE;
                end
            end
            // R6: no bank reads while a grant is withheld for a write
            p_write_owns_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_req |-> (bank_op[g] == BANK_WRITE) && !rd_grant[g]);
        end
    endgenerate

endmodule

// File: rtl/mirror_rd4_mem.sv
// Module: four-read-port memory built from mirrored single-port banks.
// Each read port owns one bank; writes go to all banks at once.
// Read data is valid one cycle after a granted request.
// Assumes: synchronous active-low reset; contents are undefined until written.
module mirror_rd4_mem
    import mrm_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 32,
    parameter int NPORTS = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        rd_req,
    input  logic [NPORTS*AW-1:0]     rd_addr,
    output logic [NPORTS-1:0]        rd_ready,
    output logic                     rd_stall,
    output logic [NPORTS-1:0]        rd_valid,
    output logic [NPORTS*WIDTH-1:0]  rd_data,
    input  logic                     wr_req,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WIDTH-1:0]         wr_data
);

    bank_op_e          bank_op [NPORTS];
    logic [NPORTS-1:0] grant;

    mrm_arbiter #(
        .NPORTS (NPORTS)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .rd_grant (grant),
        .rd_stall (rd_stall),
        .bank_op  (bank_op)
    );

    assign rd_ready = grant;

    // Valid flags: one cycle after a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
        end else begin
            rd_valid <= grant;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPORTS; g++) begin : g_bank
            logic [AW-1:0] bank_addr;

            // Address mux: the write address wins over the port's read address.
            always_comb begin
                bank_addr = wr_req ? wr_addr : rd_addr[g*AW +: AW];
            end

            mrm_bank #(
                .DEPTH (DEPTH),
                .WIDTH (WIDTH)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .op    (bank_op[g]),
                .addr  (bank_addr),
                .wdata (wr_data),
                .rdata (rd_data[g*WIDTH +: WIDTH])
            );

            // R3: an accepted read yields valid next cycle
            p_valid_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_req[g] && !wr_req) |=> rd_valid[g]);
            // R6: a read refused by a write yields no valid
            p_stalled_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_req[g] && wr_req) |=> !rd_valid[g]);
            // R9: no request, no valid
            p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_req[g] |=> !rd_valid[g]);

            if (g > 0) begin : g_mirror
                // R5: copies agree when two ports read the same word
                p_mirror_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_valid[0] && rd_valid[g] &&
                     ($past(rd_addr[0 +: AW]) == $past(rd_addr[g*AW +: AW])))
                    |-> (rd_data[0 +: WIDTH] == rd_data[g*WIDTH +: WIDTH]));
            end
        end
    endgenerate

endmodule

// File: tb/mirror_rd4_mem_tb.sv
// Bench: behavioural reference array, compared on every clock.
module mirror_rd4_mem_tb;

    localparam int DEPTH  = 64;
    localparam int WIDTH  = 32;
    localparam int NPORTS = 4;
    localparam int AW     = $clog2(DEPTH);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NPORTS-1:0]       rd_req = '0;
    logic [NPORTS*AW-1:0]    rd_addr = '0;
    logic [NPORTS-1:0]       rd_ready;
    logic                    rd_stall;
    logic [NPORTS-1:0]       rd_valid;
    logic [NPORTS*WIDTH-1:0] rd_data;
    logic                    wr_req = 1'b0;
    logic [AW-1:0]           wr_addr = '0;
    logic [WIDTH-1:0]        wr_data = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic             last_wr = 1'b0;
    logic [AW-1:0]    last_waddr = '0;

    always #5 clk = ~clk;

    mirror_rd4_mem #(
        .DEPTH (DEPTH), .WIDTH (WIDTH), .NPORTS (NPORTS)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_ready (rd_ready), .rd_stall (rd_stall),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .wr_req (wr_req), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check grants, then outputs after the edge.
    task automatic step(input logic [NPORTS-1:0] req, input logic [NPORTS*AW-1:0] addrs,
                        input logic wr, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd);
        logic [NPORTS-1:0] exp_v;
        logic [WIDTH-1:0]  exp_d [NPORTS];
        logic              raw [NPORTS];
        @(negedge clk);
        rd_req = req; rd_addr = addrs; wr_req = wr; wr_addr = wa; wr_data = wd;
        #1;
        if (wr) begin
            check("R6 rd_ready under write", 64'(rd_ready), 64'(0));
            check("R6 rd_stall", 64'(rd_stall), 64'(|req));
        end else begin
            check("R2 rd_ready", 64'(rd_ready), 64'(req));
            check("R2 rd_stall", 64'(rd_stall), 64'(0));
        end
        exp_v = wr ? '0 : req;
        for (int i = 0; i < NPORTS; i++) begin
            exp_d[i] = ref_mem[addrs[i*AW +: AW]];
            raw[i]   = last_wr && (addrs[i*AW +: AW] == last_waddr);
        end
        if (wr) ref_mem[wa] = wd;
        last_wr = wr; last_waddr = wa;
        @(posedge clk);
        #1;
        for (int i = 0; i < NPORTS; i++) begin
            check(wr ? "R6 valid after stall" : (req[i] ? "R3 valid" : "R9 idle valid"),
                  64'(rd_valid[i]), 64'(exp_v[i]));
            if (exp_v[i])
                check(raw[i] ? "R8 read-after-write data" : "R4 R10 port data",
                      64'(rd_data[i*WIDTH +: WIDTH]), 64'(exp_d[i]));
        end
    endtask

    function automatic logic [NPORTS*AW-1:0] pack4(input int a0, input int a1,
                                                   input int a2, input int a3);
        return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    endfunction

    initial begin
        // Watchdog: an expired run counts as a failure.
        #(10 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", 64'(rd_valid), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        // R5: fill every word through the write channel.
        for (int a = 0; a < DEPTH; a++)
            step('0, '0, 1'b1, AW'(a), WIDTH'(32'hA5000000 + a * 32'h01010101));
        // R4/R10: four different addresses at once.
        step(4'b1111, pack4(3, 17, 40, 63), 1'b0, '0, '0);
        step(4'b0101, pack4(0, 9, 9, 2), 1'b0, '0, '0);
        // R6: write with all reads requested; R7: retry afterwards.
        step(4'b1111, pack4(5, 6, 7, 5), 1'b1, AW'(5), 32'hDEADBEEF);
        step(4'b1111, pack4(5, 6, 7, 5), 1'b0, '0, '0);
        // R8: read the same address right after the write.
        step('0, '0, 1'b1, AW'(12), 32'h12345678);
        step(4'b1111, pack4(12, 12, 12, 12), 1'b0, '0, '0);
        // R9: idle cycle.
        step('0, pack4(1, 2, 3, 4), 1'b0, '0, '0);
        // Mixed random traffic.
        for (int c = 0; c < 3000; c++) begin
            logic [NPORTS*AW-1:0] ad;
            ad = NPORTS*AW'($urandom);
            if (c % 4 == 1) ad[AW-1:0] = last_waddr;
            step(NPORTS'($urandom), ad, ($urandom % 4) == 0,
                 AW'($urandom), WIDTH'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule